// File: doc/BRIEF.md
# Floating-Point Condition Predicate and Control-Flow Resolver

This block takes a 6-bit floating-point condition predicate and the three condition bits of the floating-point status (negative, zero, not-a-number). It decides whether the condition holds and flags predicates outside the legal range. When a signaling predicate meets an unordered operand, it raises the branch-unordered exception. All other current exception bits are cleared before the predicate is evaluated.

The same cycle, it works out what the instruction does to control flow. A short or long branch gets its next-PC offset. A decrement-and-loop gets its new 16-bit counter and offset. A conditional set gets its result byte. A conditional trap gets its trap decision. The instruction's displacement words and the low half of the counter register arrive as inputs, already fetched. Results are registered and appear one clock after `valid_i`.

Top module: `fp_cond_resolver`

## Requirements
- R1: A predicate of 0x20 or above sets `illegal_o`. It forces `cond_o`, `exc_o`, `pc_off_o`, `count_wr_o`, `set_wr_o`, `trap_o` and `fault_o` to zero.
- R2: Bits [2:0] of the predicate select a base test on `cc_i` = {nan, zero, neg} (bits 2, 1, 0). The tests are: 0 false; 1 zero; 2 none of nan, zero or neg; 3 zero, or neither nan nor neg; 4 neg with neither nan nor zero; 5 zero, or neg without nan; 6 neither nan nor zero; 7 not nan.
- R3: When predicate bit 3 is set, the low four bits are XORed with 0xF to give the base test, and the outcome is inverted.
- R4: `exc_o` is the exception byte after evaluation. Every bit is zero except bit 7 (branch-unordered). Bit 7 is one exactly when predicate bit 4 is set, the predicate is legal, and nan is set.
- R5: Kind 0 (short branch) sign-extends `disp_lo_i` to 32 bits. If taken, `pc_off_o` is the displacement plus 2. If not taken, `pc_off_o` is 4.
- R6: Kind 1 (long branch) uses {`disp_hi_i`, `disp_lo_i`} as the displacement. If taken, `pc_off_o` is the displacement plus 2. If not taken, `pc_off_o` is 6.
- R7: For the two branch kinds, `fault_o` is set when `exc_o & enable_i` is non-zero, and `pc_off_o` is then 0. For other kinds, `fault_o` is 0.
- R8: For kind 2 (decrement-and-loop) with a true condition, `pc_off_o` is 6 and the counter is not written.
- R9: For kind 2 with a false condition, `count_wr_o` is set and `count_o` is `count_i` minus 1 modulo 2^16. `pc_off_o` is 6 when `count_i` was 0, and otherwise 4 plus the sign-extended `disp_lo_i`.
- R10: For kind 3 with `opmode_i` equal to 2, 3 or 4, the instruction is a conditional trap of length 6, 8 or 4. `trap_o` equals the condition, and `pc_off_o` is the length.
- R11: For kind 3 with any other `opmode_i`, the instruction is a conditional set. `set_wr_o` is set, `set_byte_o` is 0xFF when the condition is true and 0x00 when it is false, and `pc_off_o` is 4.
- R12: Results appear one clock after `valid_i`, with `valid_o` high. The strobes `illegal_o`, `count_wr_o`, `set_wr_o`, `trap_o` and `fault_o` are low whenever `valid_o` is low. After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| kind_i | input | 2 | 0 short branch, 1 long branch, 2 decrement-and-loop, 3 trap/set |
| pred_i | input | 6 | Condition predicate |
| cc_i | input | 3 | {nan, zero, neg} condition bits |
| opmode_i | input | 3 | Operand mode for kind 3 |
| disp_hi_i | input | 16 | High displacement word (long branch) |
| disp_lo_i | input | 16 | Low or only displacement word |
| count_i | input | 16 | Low half of the loop counter |
| enable_i | input | 8 | Exception enable byte |
| valid_o | output | 1 | Result valid |
| illegal_o | output | 1 | Predicate out of range |
| cond_o | output | 1 | Condition outcome |
| exc_o | output | 8 | Exception byte after evaluation |
| fault_o | output | 1 | Enabled exception on a branch |
| pc_off_o | output | 32 | Next-PC offset |
| count_o | output | 16 | New loop counter |
| count_wr_o | output | 1 | Counter write strobe |
| set_byte_o | output | 8 | Conditional set byte |
| set_wr_o | output | 1 | Set byte write strobe |
| trap_o | output | 1 | Take trap |

## Verification
A wrong base-test selection or a missed inversion shows at the ports as a wrong `cond_o` the cycle after the request. The same error also flips `pc_off_o`, `set_byte_o`, `trap_o` or `count_wr_o`, depending on the instruction kind. A bad unordered-exception term changes `exc_o` and, on branches with the bit enabled, `fault_o` and a zeroed offset. An off-by-one in the counter or the sign extension shows in `count_o` or `pc_off_o` on that same result. The sweep over every predicate and every condition-bit pattern exposes a wrong predicate within one request, and the reference model is compared on every clock.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    K_BR_SHORT = 2'd0,
    K_BR_LONG  = 2'd1,
    K_LOOP     = 2'd2,
    K_TRAPSET  = 2'd3
  } fpc_kind_e;

  typedef struct packed {
    logic nan;
    logic zero;
    logic neg;
  } fpc_cc_t;
endpackage

// File: rtl/fpc_pred_eval.sv
module fpc_pred_eval
  import fpc_pkg::*;
#(
  parameter int PRED_W = 6
) (
  input  logic [PRED_W-1:0] pred_i,
  input  fpc_cc_t           cc_i,
  output logic              illegal_o,
  output logic              cond_o,
  output logic              bsun_o
);
  logic [3:0] low4;
  logic [2:0] base;
  logic       negate, raw;

  always_comb begin
    illegal_o = |pred_i[PRED_W-1:5];
    negate    = pred_i[3];
    low4      = negate ? (pred_i[3:0] ^ 4'hF) : pred_i[3:0];
    base      = low4[2:0];
    unique case (base)
      3'd0: raw = 1'b0;
      3'd1: raw = cc_i.zero;
      3'd2: raw = ~(cc_i.nan | cc_i.zero | cc_i.neg);
      3'd3: raw = cc_i.zero | ~(cc_i.nan | cc_i.neg);
      3'd4: raw = cc_i.neg & ~cc_i.nan & ~cc_i.zero;
      3'd5: raw = cc_i.zero | (cc_i.neg & ~cc_i.nan);
      3'd6: raw = ~(cc_i.nan | cc_i.zero);
      default: raw = ~cc_i.nan;
    endcase
    cond_o = ~illegal_o & (raw ^ negate);
    bsun_o = ~illegal_o & pred_i[4] & cc_i.nan;
  end
endmodule

// File: rtl/fpc_flow_resolve.sv
module fpc_flow_resolve
  import fpc_pkg::*;
#(
  parameter int DISP_W = 16,
  parameter int CNT_W  = 16,
  parameter int EXC_W  = 8,
  parameter int SET_W  = 8,
  localparam int OFF_W = 2 * DISP_W
) (
  input  fpc_kind_e          kind_i,
  input  logic               cond_i,
  input  logic               illegal_i,
  input  logic [EXC_W-1:0]   exc_i,
  input  logic [EXC_W-1:0]   enable_i,
  input  logic [2:0]         opmode_i,
  input  logic [DISP_W-1:0]  disp_hi_i,
  input  logic [DISP_W-1:0]  disp_lo_i,
  input  logic [CNT_W-1:0]   count_i,
  output logic [OFF_W-1:0]   pc_off_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               count_wr_o,
  output logic [SET_W-1:0]   set_byte_o,
  output logic               set_wr_o,
  output logic               trap_o,
  output logic               fault_o
);
  logic [OFF_W-1:0] disp_short, disp_long, disp_sel, br_len, trap_len;
  logic             fault_any, is_trap;

  assign disp_short = {{DISP_W{disp_lo_i[DISP_W-1]}}, disp_lo_i};
  assign disp_long  = {disp_hi_i, disp_lo_i};
  assign fault_any  = |(exc_i & enable_i);

  always_comb begin
    is_trap  = 1'b1;
    trap_len = OFF_W'(4);
    unique case (opmode_i)
      3'd2:    trap_len = OFF_W'(6);
      3'd3:    trap_len = OFF_W'(8);
      3'd4:    trap_len = OFF_W'(4);
      default: is_trap  = 1'b0;
    endcase
  end

  always_comb begin
    pc_off_o   = '0;
    count_o    = count_i;
    count_wr_o = 1'b0;
    set_byte_o = '0;
    set_wr_o   = 1'b0;
    trap_o     = 1'b0;
    fault_o    = 1'b0;
    disp_sel   = (kind_i == K_BR_LONG) ? disp_long : disp_short;
    br_len     = (kind_i == K_BR_LONG) ? OFF_W'(6) : OFF_W'(4);
    if (!illegal_i) begin
      unique case (kind_i)
        K_BR_SHORT, K_BR_LONG: begin
          fault_o  = fault_any;
          // offset withheld when an enabled exception is pending
          if (fault_any)   pc_off_o = '0;
          else if (cond_i) pc_off_o = disp_sel + OFF_W'(2);
          else             pc_off_o = br_len;
        end
        K_LOOP: begin
          if (cond_i) pc_off_o = OFF_W'(6);
          else begin
            count_wr_o = 1'b1;
            count_o    = count_i - 1'b1;
            pc_off_o   = (count_i == '0) ? OFF_W'(6) : disp_short + OFF_W'(4);
          end
        end
        default: begin
          if (is_trap) begin
            trap_o   = cond_i;
            pc_off_o = trap_len;
          end else begin
            set_wr_o   = 1'b1;
            set_byte_o = {SET_W{cond_i}};
            pc_off_o   = OFF_W'(4);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fp_cond_resolver.sv
module fp_cond_resolver
  import fpc_pkg::*;
#(
  parameter int PRED_W   = 6,
  parameter int DISP_W   = 16,
  parameter int CNT_W    = 16,
  parameter int EXC_W    = 8,
  parameter int BSUN_BIT = 7,
  localparam int OFF_W   = 2 * DISP_W,
  localparam int SET_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        kind_i,
  input  logic [PRED_W-1:0] pred_i,
  input  logic [2:0]        cc_i,
  input  logic [2:0]        opmode_i,
  input  logic [DISP_W-1:0] disp_hi_i,
  input  logic [DISP_W-1:0] disp_lo_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [EXC_W-1:0]  enable_i,
  output logic              valid_o,
  output logic              illegal_o,
  output logic              cond_o,
  output logic [EXC_W-1:0]  exc_o,
  output logic              fault_o,
  output logic [OFF_W-1:0]  pc_off_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              count_wr_o,
  output logic [SET_W-1:0]  set_byte_o,
  output logic              set_wr_o,
  output logic              trap_o
);
  localparam logic [EXC_W-1:0] BSUN_MASK = EXC_W'(1) << BSUN_BIT;

  logic             ev_illegal, ev_cond, ev_bsun;
  logic [EXC_W-1:0] ev_exc;
  logic [OFF_W-1:0] fr_off;
  logic [CNT_W-1:0] fr_cnt;
  logic [SET_W-1:0] fr_byte;
  logic             fr_cwr, fr_swr, fr_trap, fr_fault;

  fpc_pred_eval #(.PRED_W(PRED_W)) u_eval (
    .pred_i    (pred_i),
    .cc_i      (fpc_cc_t'(cc_i)),
    .illegal_o (ev_illegal),
    .cond_o    (ev_cond),
    .bsun_o    (ev_bsun)
  );

  // all current exceptions cleared, then the unordered bit re-raised
  assign ev_exc = ev_bsun ? BSUN_MASK : '0;

  fpc_flow_resolve #(
    .DISP_W (DISP_W),
    .CNT_W  (CNT_W),
    .EXC_W  (EXC_W),
    .SET_W  (SET_W)
  ) u_flow (
    .kind_i     (fpc_kind_e'(kind_i)),
    .cond_i     (ev_cond),
    .illegal_i  (ev_illegal),
    .exc_i      (ev_exc),
    .enable_i   (enable_i),
    .opmode_i   (opmode_i),
    .disp_hi_i  (disp_hi_i),
    .disp_lo_i  (disp_lo_i),
    .count_i    (count_i),
    .pc_off_o   (fr_off),
    .count_o    (fr_cnt),
    .count_wr_o (fr_cwr),
    .set_byte_o (fr_byte),
    .set_wr_o   (fr_swr),
    .trap_o     (fr_trap),
    .fault_o    (fr_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      illegal_o  <= 1'b0;
      count_wr_o <= 1'b0;
      set_wr_o   <= 1'b0;
      trap_o     <= 1'b0;
      fault_o    <= 1'b0;
      cond_o     <= 1'b0;
      exc_o      <= '0;
      pc_off_o   <= '0;
      count_o    <= '0;
      set_byte_o <= '0;
    end else begin
      valid_o    <= valid_i;
      illegal_o  <= valid_i & ev_illegal;
      count_wr_o <= valid_i & fr_cwr;
      set_wr_o   <= valid_i & fr_swr;
      trap_o     <= valid_i & fr_trap;
      fault_o    <= valid_i & fr_fault;
      if (valid_i) begin
        cond_o     <= ev_cond;
        exc_o      <= ev_exc;
        pc_off_o   <= fr_off;
        count_o    <= fr_cnt;
        set_byte_o <= fr_byte;
      end
    end
  end

  // R1
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !(count_wr_o || set_wr_o || trap_o || fault_o || cond_o) && pc_off_o == '0 && exc_o == '0);
  // R4
  only_unordered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (exc_o & ~BSUN_MASK) == '0);
  // R4
  unordered_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && exc_o[BSUN_BIT]) |-> ($past(pred_i[4]) && $past(cc_i[2])));
  // R7
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> pc_off_o == '0 && $past(kind_i) <= 2'd1);
  // R9
  count_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_wr_o |-> !cond_o && count_o == CNT_W'($past(count_i) - 1'b1));
  // R10
  trap_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> cond_o && !set_wr_o);
  // R11
  set_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr_o |-> set_byte_o == {SET_W{cond_o}} && pc_off_o == OFF_W'(4));
  // R12
  strobe_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_wr_o || set_wr_o || trap_o || fault_o || illegal_o) |-> valid_o);
endmodule

// File: tb/fp_cond_resolver_bench.sv
module fp_cond_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic [5:0]  pred_i = '0;
  logic [2:0]  cc_i = '0;
  logic [2:0]  opmode_i = '0;
  logic [15:0] disp_hi_i = '0, disp_lo_i = '0, count_i = '0;
  logic [7:0]  enable_i = '0;
  logic        valid_o, illegal_o, cond_o, fault_o, count_wr_o, set_wr_o, trap_o;
  logic [7:0]  exc_o, set_byte_o;
  logic [31:0] pc_off_o;
  logic [15:0] count_o;

  int checks = 0;
  int errors = 0;
  bit pending = 0;
  bit done = 0;

  bit          e_valid, e_ill, e_cond, e_fault, e_cw, e_sw, e_trap;
  logic [7:0]  e_exc, e_sb;
  logic [31:0] e_off;
  logic [15:0] e_cnt;
  int          e_kind;

  always #10ns clk = ~clk;

  fp_cond_resolver u_fp_cond_resolver (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .kind_i(kind_i), .pred_i(pred_i),
    .cc_i(cc_i), .opmode_i(opmode_i), .disp_hi_i(disp_hi_i), .disp_lo_i(disp_lo_i),
    .count_i(count_i), .enable_i(enable_i), .valid_o(valid_o), .illegal_o(illegal_o),
    .cond_o(cond_o), .exc_o(exc_o), .fault_o(fault_o), .pc_off_o(pc_off_o),
    .count_o(count_o), .count_wr_o(count_wr_o), .set_byte_o(set_byte_o),
    .set_wr_o(set_wr_o), .trap_o(trap_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference for one request
  task automatic model(input bit v, input int k, input int p, input int cc, input int om,
                       input int hi, input int lo, input int cnt, input int en);
    bit nan, z, n, c, inv;
    int t, slo;
    nan = cc[2]; z = cc[1]; n = cc[0];
    e_valid = v; e_kind = k;
    e_ill = 0; e_cond = 0; e_fault = 0; e_cw = 0; e_sw = 0; e_trap = 0;
    e_exc = 0; e_sb = 0; e_off = 0; e_cnt = cnt[15:0];
    if (p >= 32) begin
      e_ill = 1;
    end else begin
      t = p % 16;
      inv = (t >= 8);
      if (inv) t = 15 - t;
      case (t)
        0: c = 0;
        1: c = z;
        2: c = !nan && !z && !n;
        3: c = z || (!nan && !n);
        4: c = n && !nan && !z;
        5: c = z || (n && !nan);
        6: c = !nan && !z;
        default: c = !nan;
      endcase
      e_cond = inv ? !c : c;
      if (p >= 16 && nan) e_exc = 8'h80;
      slo = (lo >= 32768) ? lo - 65536 : lo;
      if (k == 0 || k == 1) begin
        e_fault = (e_exc & en[7:0]) != 0;
        if (e_fault) e_off = 0;
        else if (e_cond) e_off = (k == 1) ? ((hi << 16) + lo + 2) : (slo + 2);
        else e_off = (k == 1) ? 6 : 4;
      end else if (k == 2) begin
        if (e_cond) e_off = 6;
        else begin
          e_cw = 1;
          e_cnt = (cnt + 65535) % 65536;
          e_off = (cnt == 0) ? 6 : slo + 4;
        end
      end else begin
        if (om == 2 || om == 3 || om == 4) begin
          e_trap = e_cond;
          e_off = (om == 2) ? 6 : (om == 3) ? 8 : 4;
        end else begin
          e_sw = 1;
          e_sb = e_cond ? 8'hFF : 8'h00;
          e_off = 4;
        end
      end
    end
    if (!v) begin
      e_ill = 0; e_fault = 0; e_cw = 0; e_sw = 0; e_trap = 0;
    end
  endtask

  task automatic compare();
    chk("R12 valid", valid_o, e_valid);
    chk("R1 illegal", illegal_o, e_ill);
    chk("R7 fault", fault_o, e_fault);
    chk("R9 count_wr", count_wr_o, e_cw);
    chk("R11 set_wr", set_wr_o, e_sw);
    chk("R10 trap", trap_o, e_trap);
    if (e_valid) begin
      chk("R2 R3 cond", cond_o, e_cond);
      chk("R4 exc", exc_o, e_exc);
      case (e_kind)
        0: chk("R5 pc_off", pc_off_o, e_off);
        1: chk("R6 pc_off", pc_off_o, e_off);
        2: chk("R8 pc_off", pc_off_o, e_off);
        default: chk("R10 R11 pc_off", pc_off_o, e_off);
      endcase
      if (e_cw) chk("R9 count", count_o, e_cnt);
      if (e_sw) chk("R11 byte", set_byte_o, e_sb);
    end
  endtask

  task automatic drive(input bit v, input int k, input int p, input int cc, input int om,
                       input int hi, input int lo, input int cnt, input int en);
    @(negedge clk);
    if (pending) compare();
    valid_i = v; kind_i = k[1:0]; pred_i = p[5:0]; cc_i = cc[2:0]; opmode_i = om[2:0];
    disp_hi_i = hi[15:0]; disp_lo_i = lo[15:0]; count_i = cnt[15:0]; enable_i = en[7:0];
    model(v, k, p, cc, om, hi, lo, cnt, en);
    pending = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset valid", valid_o, 0);
    chk("R12 reset pc_off", pc_off_o, 0);
    chk("R12 reset strobes", {illegal_o, fault_o, count_wr_o, set_wr_o, trap_o, cond_o}, 0);
    chk("R12 reset exc", exc_o, 0);
    rst_n = 1'b1;
    // R1 illegal predicates
    drive(1, 0, 6'h20, 2, 0, 0, 16'h0010, 0, 8'hFF);
    drive(1, 2, 6'h3F, 7, 0, 0, 16'h0010, 3, 8'hFF);
    drive(1, 3, 6'h2F, 0, 0, 0, 0, 0, 0);
    // R5 short branch taken backward, and not taken
    drive(1, 0, 6'h01, 2, 0, 0, 16'hFFF0, 0, 0);
    drive(1, 0, 6'h01, 0, 0, 0, 16'hFFF0, 0, 0);
    // R6 / R3 long branch with negated false (always true), then false
    drive(1, 1, 6'h0F, 0, 0, 16'h0001, 16'h0000, 0, 0);
    drive(1, 1, 6'h00, 0, 0, 16'h0001, 16'h0000, 0, 0);
    // R4 / R7 signaling predicate on NaN, enabled and disabled
    drive(1, 0, 6'h11, 4, 0, 0, 16'h0100, 0, 8'h80);
    drive(1, 1, 6'h11, 4, 0, 0, 16'h0100, 0, 8'h7F);
    drive(1, 0, 6'h01, 4, 0, 0, 16'h0100, 0, 8'hFF);
    // R8 / R9 loop
    drive(1, 2, 6'h0F, 0, 0, 0, 16'hFFFC, 5, 0);
    drive(1, 2, 6'h00, 0, 0, 0, 16'hFFFC, 5, 0);
    drive(1, 2, 6'h00, 0, 0, 0, 16'hFFFC, 0, 0);
    drive(1, 2, 6'h00, 0, 0, 0, 16'h0020, 16'h8000, 0);
    // R10 traps, R11 sets
    for (int om = 0; om < 8; om++) begin
      drive(1, 3, 6'h0F, 0, om, 0, 0, 0, 0);
      drive(1, 3, 6'h00, 0, om, 0, 0, 0, 0);
    end
    // R2 / R3 / R4 full predicate sweep through conditional set
    for (int p = 0; p < 64; p++)
      for (int cc = 0; cc < 8; cc++)
        drive(1, 3, p, cc, 0, 0, 0, 0, 0);
    // R12 idle cycles carry junk
    drive(0, 3, 6'h0F, 0, 0, 0, 0, 0, 0);
    drive(0, 2, 6'h00, 0, 0, 0, 0, 9, 0);
    for (int i = 0; i < 1500; i++)
      drive(($urandom % 8) != 0, $urandom % 4, $urandom % 64, $urandom % 8, $urandom % 8,
            $urandom % 65536, $urandom % 65536, $urandom % 65536, $urandom % 256);
    @(negedge clk);
    compare();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R12 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule